// File: doc/BRIEF.md
# Sprite Link Scanner

Once per scanline this block decides which sprites the line will show. The sprite attributes sit in a small table outside the block. Each table entry gives a top row, a height in pixels, a width in pixels and a 7-bit link to the next entry. After a start pulse the scanner reads one entry per clock. It begins at entry 0 and follows the links from there. Every entry whose rows include the current line is appended to a per-line list.

The walk ends as soon as any one of five limits is reached:

- the link is zero;
- the link points past the table;
- the list is full;
- the accumulated tile cost hits its budget;
- a visit counter hits its cap.

Because of the visit cap, a corrupted table whose links form a cycle still ends in a bounded number of clocks. A one-cycle done pulse marks the end of the walk. The list and its count stay on the outputs until the next accepted start, where the rendering stage can read them.

Top module: `sprite_chain_scan`

## Requirements
- R1: After reset `done` is 0 and `obj_count` is 0.
- R2: An accepted start latches `line`. In the next cycle the scanner presents table address 0, and each later cycle presents the link value of the entry read in the cycle before.
- R3: An entry is appended only if `y <= line < y + height`. An entry that fails this test adds nothing, but its link is still followed. Slot k of `obj_list` is bits [7k+6:7k] and holds the k-th appended entry index, in visit order.
- R4: The walk ends after visiting an entry whose link is 0.
- R5: The walk ends after visiting an entry whose link is 80 or greater. Such a link is never presented as an address.
- R6: The walk ends on the visit that brings the list to 20 entries.
- R7: Each appended entry adds width/8 (rounded down) to a tile total. The walk ends on the visit where that total becomes 40 or more.
- R8: The walk ends on the 80th visit even when the links form a cycle.
- R9: `done` is high for exactly one cycle, in the cycle after the last visit. A walk of v visits raises `done` v clock edges after the start edge. `obj_count` and `obj_list` then hold until the next accepted start, whatever `line` does.
- R10: A start pulse during a walk is ignored. The walk's length and result do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk for `line` (accepted only when idle) |
| line | input | 10 | Current scanline |
| tbl_addr | output | 7 | Attribute table entry being read |
| tbl_y | input | 10 | Top row of the addressed entry |
| tbl_height | input | 6 | Height in pixels of the addressed entry |
| tbl_width | input | 6 | Width in pixels of the addressed entry |
| tbl_link | input | 7 | Link field of the addressed entry |
| obj_list | output | 140 | Appended entry indices, 7 bits per slot |
| obj_count | output | 5 | Number of valid slots in `obj_list` |
| done | output | 1 | One-cycle pulse at the end of a walk |

## Verification
The bench uses the default parameters: 80 table entries, a 20-entry list, a 40-tile budget and an 80-visit cap. With these values every limit can be reached from a real table. A straight chain of 80 visible entries runs into the list limit. Sprites 32 and 48 pixels wide run into the tile budget. A three-entry cycle runs into the visit cap, and a variant of it fills the list before the cap. Each of these walks has its own expected length, count and last list entry. The bench also checks the walk length, which pins down on which visit each limit takes effect.

// File: rtl/sprite_scan_pkg.sv
package sprite_scan_pkg;

  // Vertical coverage test: top <= ln < top + ht, computed one bit wider.
  function automatic logic span_hit(input logic [15:0] ln, input logic [15:0] top,
                                    input logic [15:0] ht);
    logic [16:0] bottom;
    bottom = {1'b0, top} + {1'b0, ht};
    return ({1'b0, ln} >= {1'b0, top}) && ({1'b0, ln} < bottom);
  endfunction

  // Tile cost of a sprite: its width in whole 8-pixel cells.
  function automatic logic [15:0] tile_cost(input logic [15:0] wd);
    return wd >> 3;
  endfunction

endpackage

// File: rtl/scan_range_test.sv
module scan_range_test
  import sprite_scan_pkg::*;
#(
  parameter int Y_W    = 10,
  parameter int H_W    = 6,
  parameter int W_W    = 6,
  parameter int TILE_W = 6
) (
  input  logic [Y_W-1:0]    line,
  input  logic [Y_W-1:0]    top,
  input  logic [H_W-1:0]    height,
  input  logic [W_W-1:0]    width,
  output logic              hit,
  output logic [TILE_W-1:0] tile_add
);
  assign hit      = span_hit(16'(line), 16'(top), 16'(height));
  assign tile_add = TILE_W'(tile_cost(16'(width)));
endmodule

// File: rtl/scan_stop_logic.sv
module scan_stop_logic #(
  parameter int LINK_W      = 7,
  parameter int NUM_ENTRIES = 80,
  parameter int MAX_OBJ     = 20,
  parameter int MAX_TILES   = 40,
  parameter int MAX_VISITS  = 80,
  parameter int OBJ_CW      = 5,
  parameter int TILE_CW     = 6,
  parameter int VIS_CW      = 7
) (
  input  logic [LINK_W-1:0]  next_link,
  input  logic [OBJ_CW-1:0]  obj_next,
  input  logic [TILE_CW-1:0] tile_next,
  input  logic [VIS_CW-1:0]  visit_next,
  output logic               stop_end,
  output logic               stop_range,
  output logic               stop_obj,
  output logic               stop_tile,
  output logic               stop_visit,
  output logic               stop
);
  assign stop_end   = (next_link == '0);
  assign stop_range = (int'(next_link) >= NUM_ENTRIES);
  assign stop_obj   = (int'(obj_next) >= MAX_OBJ);
  assign stop_tile  = (int'(tile_next) >= MAX_TILES);
  assign stop_visit = (int'(visit_next) >= MAX_VISITS);
  assign stop       = stop_end | stop_range | stop_obj | stop_tile | stop_visit;
endmodule

// File: rtl/sprite_chain_scan.sv
module sprite_chain_scan #(
  parameter int NUM_ENTRIES = 80,
  parameter int LINK_W      = 7,
  parameter int Y_W         = 10,
  parameter int H_W         = 6,
  parameter int W_W         = 6,
  parameter int MAX_OBJ     = 20,
  parameter int MAX_TILES   = 40,
  parameter int MAX_VISITS  = 80,
  localparam int OBJ_CW     = $clog2(MAX_OBJ + 1),
  localparam int LIST_W     = MAX_OBJ * LINK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [Y_W-1:0]    line,
  output logic [LINK_W-1:0] tbl_addr,
  input  logic [Y_W-1:0]    tbl_y,
  input  logic [H_W-1:0]    tbl_height,
  input  logic [W_W-1:0]    tbl_width,
  input  logic [LINK_W-1:0] tbl_link,
  output logic [LIST_W-1:0] obj_list,
  output logic [OBJ_CW-1:0] obj_count,
  output logic              done
);
  localparam int TILE_CW = $clog2(MAX_TILES + (2 ** W_W) / 8 + 1);
  localparam int VIS_CW  = $clog2(MAX_VISITS + 1);

  logic               busy_q;
  logic [LINK_W-1:0]  addr_q;
  logic [Y_W-1:0]     line_q;
  logic [OBJ_CW-1:0]  obj_q;
  logic [TILE_CW-1:0] tile_q;
  logic [VIS_CW-1:0]  vis_q;
  logic               done_q;
  logic [LINK_W-1:0]  list_q [MAX_OBJ];

  // Named internal events
  logic               entry_hit;
  logic [TILE_CW-1:0] entry_tiles;
  logic               accept_start;
  logic               append_now;
  logic [OBJ_CW-1:0]  obj_next;
  logic [TILE_CW-1:0] tile_next;
  logic [VIS_CW-1:0]  vis_next;
  logic stop_end, stop_range, stop_obj, stop_tile, stop_visit, stop_any;

  scan_range_test #(.Y_W(Y_W), .H_W(H_W), .W_W(W_W), .TILE_W(TILE_CW)) u_range (
    .line(line_q), .top(tbl_y), .height(tbl_height), .width(tbl_width),
    .hit(entry_hit), .tile_add(entry_tiles)
  );

  assign accept_start = start && !busy_q;
  assign append_now   = busy_q && entry_hit;
  assign obj_next     = obj_q + OBJ_CW'(append_now);
  assign tile_next    = tile_q + (append_now ? entry_tiles : '0);
  assign vis_next     = vis_q + VIS_CW'(1);

  scan_stop_logic #(
    .LINK_W(LINK_W), .NUM_ENTRIES(NUM_ENTRIES), .MAX_OBJ(MAX_OBJ),
    .MAX_TILES(MAX_TILES), .MAX_VISITS(MAX_VISITS),
    .OBJ_CW(OBJ_CW), .TILE_CW(TILE_CW), .VIS_CW(VIS_CW)
  ) u_stop (
    .next_link(tbl_link), .obj_next(obj_next), .tile_next(tile_next),
    .visit_next(vis_next), .stop_end(stop_end), .stop_range(stop_range),
    .stop_obj(stop_obj), .stop_tile(stop_tile), .stop_visit(stop_visit),
    .stop(stop_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      line_q <= '0;
      obj_q  <= '0;
      tile_q <= '0;
      vis_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q && stop_any;
      if (accept_start) begin
        busy_q <= 1'b1;
        addr_q <= '0;
        line_q <= line;
        obj_q  <= '0;
        tile_q <= '0;
        vis_q  <= '0;
      end else if (busy_q) begin
        obj_q  <= obj_next;
        tile_q <= tile_next;
        vis_q  <= vis_next;
        if (stop_any) busy_q <= 1'b0;
        else          addr_q <= tbl_link;
      end
    end
  end

  // One storage slot per list position
  for (genvar g = 0; g < MAX_OBJ; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                    list_q[g] <= '0;
      else if (append_now && obj_q == OBJ_CW'(g))    list_q[g] <= addr_q;
    end
    assign obj_list[g*LINK_W +: LINK_W] = list_q[g];
  end

  assign tbl_addr  = addr_q;
  assign obj_count = obj_q;
  assign done      = done_q;
endmodule

// File: rtl/sprite_chain_scan_chk.sv
module sprite_chain_scan_chk #(
  parameter int NUM_ENTRIES = 80,
  parameter int LINK_W      = 7,
  parameter int MAX_OBJ     = 20,
  parameter int MAX_VISITS  = 80,
  parameter int OBJ_CW      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              stop,
  input logic              done,
  input logic [LINK_W-1:0] tbl_addr,
  input logic [OBJ_CW-1:0] obj_count
);
  localparam int WC_W = $clog2(MAX_VISITS + 2);
  logic [WC_W-1:0] walk_cyc;

  always_ff @(posedge clk) begin
    if (!rst_n)               walk_cyc <= '0;
    else if (start && !busy)  walk_cyc <= '0;
    else if (busy)            walk_cyc <= walk_cyc + WC_W'(1);
  end

  AST_FIRST_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (tbl_addr == '0)); // R2
  AST_ADDR_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(tbl_addr) < NUM_ENTRIES)); // R5
  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(obj_count) <= MAX_OBJ); // R6
  AST_VISIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(walk_cyc) <= MAX_VISITS); // R8
  AST_STOP_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop) |=> (done && !busy)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(obj_count)); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !stop) |=> (busy && !done)); // R10
endmodule

bind sprite_chain_scan sprite_chain_scan_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .LINK_W(LINK_W), .MAX_OBJ(MAX_OBJ),
  .MAX_VISITS(MAX_VISITS), .OBJ_CW(OBJ_CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_q), .stop(stop_any),
  .done(done), .tbl_addr(tbl_addr), .obj_count(obj_count)
);

// File: tb/sim_sprite_chain_scan.sv
`timescale 1ns/1ps
module sim_sprite_chain_scan;
  localparam int N = 80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [9:0]  line = '0;
  logic [6:0]  tbl_addr;
  logic [9:0]  tbl_y;
  logic [5:0]  tbl_height;
  logic [5:0]  tbl_width;
  logic [6:0]  tbl_link;
  logic [139:0] obj_list;
  logic [4:0]  obj_count;
  logic        done;

  logic [9:0] ty [0:N-1];
  logic [5:0] th [0:N-1];
  logic [5:0] tw [0:N-1];
  logic [6:0] tl [0:N-1];

  int checks = 0;
  int errors = 0;
  int exp_cnt, exp_vis;
  int exp_list [0:19];

  always #2 clk = ~clk;

  sprite_chain_scan u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .line(line), .tbl_addr(tbl_addr),
    .tbl_y(tbl_y), .tbl_height(tbl_height), .tbl_width(tbl_width), .tbl_link(tbl_link),
    .obj_list(obj_list), .obj_count(obj_count), .done(done)
  );

  always_comb begin
    if (int'(tbl_addr) < N) begin
      tbl_y = ty[tbl_addr]; tbl_height = th[tbl_addr];
      tbl_width = tw[tbl_addr]; tbl_link = tl[tbl_addr];
    end else begin
      tbl_y = '0; tbl_height = '0; tbl_width = '0; tbl_link = '0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_ent(input int i, input int y, input int h, input int w, input int lk);
    ty[i] = 10'(y); th[i] = 6'(h); tw[i] = 6'(w); tl[i] = 7'(lk);
  endtask

  task automatic clear_table();
    for (int i = 0; i < N; i++) set_ent(i, 1000, 0, 8, 0);
  endtask

  // Expected walk from the requirement text
  task automatic model(input int ln);
    int lk, tiles, e;
    lk = 0; tiles = 0; exp_cnt = 0; exp_vis = 0;
    while (1) begin
      exp_vis++;
      e = lk;
      lk = int'(tl[e]);
      if (ln >= int'(ty[e]) && ln < int'(ty[e]) + int'(th[e])) begin
        exp_list[exp_cnt] = e;
        exp_cnt++;
        tiles += int'(tw[e]) / 8;
      end
      if (lk == 0 || lk >= 80 || exp_cnt >= 20 || tiles >= 40 || exp_vis >= 80) break;
    end
  endtask

  function automatic int slot(input int k);
    return int'(obj_list[k*7 +: 7]);
  endfunction

  // Run one walk; returns clock edges from start edge to done.
  task automatic run_scan(input int ln, input int poke_at, output int cyc);
    @(negedge clk); line = 10'(ln); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      start = (cyc == poke_at);
      if (done) break;
      if (cyc > 1000) begin
        chk("R9 done timeout", cyc, -1);
        break;
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk("R9 done single cycle", int'(done), 0);
  endtask

  task automatic check_result(input string req, input int cyc);
    chk({req, " walk length"}, cyc, exp_vis);
    chk({req, " count"}, int'(obj_count), exp_cnt);
    for (int k = 0; k < exp_cnt; k++) chk({req, " R3 list slot"}, slot(k), exp_list[k]);
  endtask

  task automatic t_reset();
    chk("R1 done after reset", int'(done), 0);
    chk("R1 count after reset", int'(obj_count), 0);
  endtask

  task automatic t_chain();
    int cyc;
    clear_table();
    set_ent(0, 90, 16, 8, 12);
    set_ent(12, 101, 8, 8, 5);
    set_ent(5, 100, 1, 8, 40);
    set_ent(40, 85, 16, 8, 0);
    model(100);
    run_scan(100, -1, cyc);
    check_result("R2 R4", cyc);
    chk("R3 skipped entry count", int'(obj_count), 3);
    chk("R2 second slot follows link", slot(1), 5);
    chk("R4 link zero length", cyc, 4);
  endtask

  task automatic t_range();
    int cyc;
    clear_table();
    set_ent(0, 0, 63, 8, 9);
    set_ent(9, 0, 63, 8, 95);
    model(10);
    run_scan(10, -1, cyc);
    check_result("R5", cyc);
    chk("R5 stop on far link", cyc, 2);
  endtask

  task automatic t_many();
    int cyc;
    clear_table();
    for (int i = 0; i < N; i++) set_ent(i, 40, 16, 8, (i + 1) % N);
    model(50);
    run_scan(50, -1, cyc);
    check_result("R6", cyc);
    chk("R6 full list", int'(obj_count), 20);
    chk("R6 last entry", slot(19), 19);
  endtask

  task automatic t_wide();
    int cyc;
    for (int i = 0; i < N; i++) set_ent(i, 40, 16, 32, (i + 1) % N);
    model(45);
    run_scan(45, -1, cyc);
    check_result("R7 w32", cyc);
    chk("R7 ten wide sprites", int'(obj_count), 10);
    for (int i = 0; i < N; i++) set_ent(i, 40, 16, 48, (i + 1) % N);
    set_ent(2, 200, 4, 48, 3);
    model(45);
    run_scan(45, -1, cyc);
    check_result("R7 w48", cyc);
    chk("R7 last entry past skip", slot(6), 7);
  endtask

  task automatic t_loop();
    int cyc;
    clear_table();
    set_ent(0, 1000, 0, 8, 1);
    set_ent(1, 1000, 0, 8, 2);
    set_ent(2, 1000, 0, 8, 3);
    set_ent(3, 1000, 0, 8, 1);
    model(20);
    run_scan(20, -1, cyc);
    check_result("R8", cyc);
    chk("R8 cycle capped", cyc, 80);
    set_ent(2, 10, 20, 8, 3);
    model(20);
    run_scan(20, -1, cyc);
    check_result("R8 R6 cycle fills list", cyc);
    chk("R8 R6 cycle fills at visit 60", cyc, 60);
  endtask

  task automatic t_ignore();
    int cyc;
    clear_table();
    for (int i = 0; i < N; i++) set_ent(i, 300, 4, 8, (i + 1) % N);
    set_ent(33, 5, 4, 8, 34);
    model(6);
    run_scan(6, 10, cyc);
    check_result("R10", cyc);
    chk("R10 restart ignored", cyc, 80);
    chk("R10 single hit kept", slot(0), 33);
  endtask

  task automatic t_hold();
    repeat (5) @(negedge clk);
    line = 10'd999;
    repeat (3) @(negedge clk);
    chk("R9 count held", int'(obj_count), 1);
    chk("R9 list held", slot(0), 33);
    chk("R9 done stays low", int'(done), 0);
  endtask

  initial begin
    #(150000 * 4);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_table();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chain();
    t_range();
    t_many();
    t_wide();
    t_loop();
    t_ignore();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule